// File: doc/BRIEF.md
# Rounding saturating fractional adder

This block is a datapath slice that reduces a 32-bit signed quantity, or the sum or difference of two of them, to a 16-bit signed result under one of three rounding windows. In the plain round mode the single operand is rounded to its upper 16 bits. In the narrow mode the sum or difference is rounded at bit 12. In the wide mode it is rounded at bit 20, which is an arithmetic shift right by 20. The first two modes saturate to the 16-bit signed range when the rounded value does not fit. The wide mode cannot leave that range.

Each accepted operation registers the 16-bit result and merges it into one half of a 32-bit destination word. The other half is taken unchanged from the destination value presented with the operation. The block also registers status flags: zero, negative, overflow, a copy of overflow, and a sticky overflow. The sticky overflow stays set until software loads the flags through a synchronous status-write port. Results and flags appear one clock after the operation is accepted.

Top module: `rnd_sat_adder`

## Requirements
- R1: With op_mode = 2'b00 (plain round), the result is bits [31:16] of src_a + 0x8000, computed without wrap. src_b and op_sub have no effect.
- R2: In plain round mode, a rounded value above 0x7fff saturates to 0x7fff and sets the overflow flag.
- R3: With op_mode = 2'b01 (narrow round), the result is (src_a ± src_b + 0x800) shifted arithmetically right by 12. A value above 0x7fff gives 0x7fff, a value below -0x8000 gives 0x8000, and either case sets overflow.
- R4: With op_mode = 2'b10 (wide round), the result is (src_a ± src_b + 0x80000) shifted arithmetically right by 20. Overflow is never set.
- R5: Flag vector bit 0 (zero) is set when the 16-bit result is 0. Bit 1 (negative) equals result bit 15.
- R6: Flag bit 2 (overflow) and bit 3 (overflow copy) are equal and describe only the latest operation.
- R7: Flag bit 4 (sticky overflow) is set by any overflowing operation. It stays set across later operations until a status write clears it.
- R8: op_hi = 1 writes the result into dst_out[31:16] and passes dst_in[15:0] to dst_out[15:0]. op_hi = 0 writes dst_out[15:0] and passes dst_in[31:16] to dst_out[31:16].
- R9: When stat_wr is high, the flags load stat_wdata on the next clock. This takes priority over an operation in the same cycle, whose result is still written.
- R10: While reset is asserted, res_out, dst_out and all flags are zero.
- R11: In cycles with neither op_valid nor stat_wr, res_out, dst_out and the flags hold their values.
- R12: op_sub = 1 selects subtraction in the narrow and wide modes. op_mode = 2'b11 behaves as plain round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| op_valid | input | 1 | Accept an operation this cycle |
| op_mode | input | 2 | 00 plain, 01 narrow (bit 12), 10 wide (bit 20), 11 plain |
| op_sub | input | 1 | Subtract src_b instead of adding it |
| op_hi | input | 1 | Write the result into the upper destination half |
| src_a | input | 32 | First signed operand |
| src_b | input | 32 | Second signed operand |
| dst_in | input | 32 | Current destination word; supplies the preserved half |
| stat_wr | input | 1 | Load the flags from stat_wdata |
| stat_wdata | input | 5 | Flag load value {sticky, ovf copy, ovf, neg, zero} |
| res_out | output | 16 | Registered 16-bit result |
| dst_out | output | 32 | Registered merged destination word |
| flags_out | output | 5 | Registered flags {sticky, ovf copy, ovf, neg, zero} |

## Verification
A status write and an operation can arrive in the same cycle. The load then has to win for every flag, the sticky bit included, while the result and destination merge still go through. The bench drives this collision on purpose with an operation that overflows, and checks three things one clock later: the flags equal the written value, the overflow is not carried into the sticky bit, and res_out and dst_out match the bench model. Random and directed operations around it confirm that the sticky bit then builds up again from the loaded value.

// File: rtl/rsa_pkg.sv
package rsa_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN  = 2'b00,
    MODE_NARROW = 2'b01,
    MODE_WIDE   = 2'b10,
    MODE_ALIAS  = 2'b11
  } rmode_e;

  // bit 4 .. bit 0
  typedef struct packed {
    logic sticky;
    logic ovf_cp;
    logic ovf;
    logic neg;
    logic zero;
  } rflags_t;

  localparam int unsigned FLAG_W = $bits(rflags_t);

  // window index used by the extraction stage
  function automatic logic [1:0] win_index(rmode_e m);
    case (m)
      MODE_NARROW: win_index = 2'd1;
      MODE_WIDE:   win_index = 2'd2;
      default:     win_index = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/rsa_sum.sv
module rsa_sum
  import rsa_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned GUARD_W  = 4,
  parameter int unsigned SH_PLAIN = 16,
  parameter int unsigned SH_NAR   = 12,
  parameter int unsigned SH_WIDE  = 20,
  localparam int unsigned EXT_W   = DATA_W + GUARD_W
) (
  input  rmode_e                   mode,
  input  logic                     sub,
  input  logic [DATA_W-1:0]        a,
  input  logic [DATA_W-1:0]        b,
  output logic signed [EXT_W-1:0]  sum
);

  logic signed [EXT_W-1:0] ext_a;
  logic signed [EXT_W-1:0] ext_b;
  logic signed [EXT_W-1:0] addend;
  logic signed [EXT_W-1:0] rnd_k;
  logic [1:0]              widx;

  assign ext_a = {{GUARD_W{a[DATA_W-1]}}, a};
  assign ext_b = {{GUARD_W{b[DATA_W-1]}}, b};
  assign widx  = win_index(mode);

  // second operand takes part only in the two-operand windows
  always_comb begin
    if (widx == 2'd0)  addend = '0;
    else if (sub)      addend = -ext_b;
    else               addend = ext_b;
  end

  // half-LSB of the selected output window
  always_comb begin
    case (widx)
      2'd1:    rnd_k = EXT_W'(1) << (SH_NAR - 1);
      2'd2:    rnd_k = EXT_W'(1) << (SH_WIDE - 1);
      default: rnd_k = EXT_W'(1) << (SH_PLAIN - 1);
    endcase
  end

  assign sum = ext_a + addend + rnd_k;

endmodule

// File: rtl/rsa_window.sv
module rsa_window
  import rsa_pkg::*;
#(
  parameter int unsigned EXT_W    = 36,
  parameter int unsigned RES_W    = 16,
  parameter int unsigned SH_PLAIN = 16,
  parameter int unsigned SH_NAR   = 12,
  parameter int unsigned SH_WIDE  = 20,
  localparam int unsigned N_WIN   = 3
) (
  input  rmode_e                  mode,
  input  logic signed [EXT_W-1:0] sum,
  output logic [RES_W-1:0]        res,
  output logic                    ovf
);

  localparam int unsigned SH_TAB [N_WIN] = '{SH_PLAIN, SH_NAR, SH_WIDE};
  localparam logic [RES_W-1:0] MAX_POS = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] MAX_NEG = {1'b1, {(RES_W-1){1'b0}}};

  logic signed [EXT_W-1:0] cand   [N_WIN];
  logic [N_WIN-1:0]        fits;
  logic [RES_W-1:0]        sat_v  [N_WIN];
  logic [1:0]              widx;

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    assign cand[g] = sum >>> SH_TAB[g];
    // in range when every bit from the result sign upward agrees
    assign fits[g] = (&cand[g][EXT_W-1:RES_W-1]) | ~(|cand[g][EXT_W-1:RES_W-1]);
    always_comb begin
      if (fits[g])                sat_v[g] = cand[g][RES_W-1:0];
      else if (cand[g][EXT_W-1])  sat_v[g] = MAX_NEG;
      else                        sat_v[g] = MAX_POS;
    end
  end

  assign widx = win_index(mode);

  always_comb begin
    case (widx)
      2'd1: begin
        res = sat_v[1];
        ovf = ~fits[1];
      end
      2'd2: begin
        res = sat_v[2];
        ovf = ~fits[2];
      end
      default: begin
        res = sat_v[0];
        ovf = ~fits[0];
      end
    endcase
  end

endmodule

// File: rtl/rsa_flags.sv
module rsa_flags
  import rsa_pkg::*;
#(
  parameter int unsigned RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_fire,
  input  logic [RES_W-1:0] res,
  input  logic             ovf,
  input  logic             ld_en,
  input  rflags_t          ld_val,
  output rflags_t          flags
);

  rflags_t flags_d;
  logic    flags_en;

  assign flags_en = ld_en | op_fire;

  always_comb begin
    flags_d = flags;
    if (ld_en) begin
      flags_d = ld_val;
    end else if (op_fire) begin
      flags_d.zero   = (res == '0);
      flags_d.neg    = res[RES_W-1];
      flags_d.ovf    = ovf;
      flags_d.ovf_cp = ovf;
      flags_d.sticky = flags.sticky | ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (flags_en) begin
      flags <= flags_d;
    end
  end

endmodule

// File: rtl/rnd_sat_adder.sv
module rnd_sat_adder
  import rsa_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned RES_W    = 16,
  parameter int unsigned SH_NAR   = 12,
  parameter int unsigned SH_WIDE  = 20,
  localparam int unsigned GUARD_W = 4,
  localparam int unsigned EXT_W   = DATA_W + GUARD_W,
  localparam int unsigned SH_PLAIN = DATA_W - RES_W,
  localparam int unsigned DST_W   = 2 * RES_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_mode,
  input  logic              op_sub,
  input  logic              op_hi,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DST_W-1:0]  dst_in,
  input  logic              stat_wr,
  input  logic [4:0]        stat_wdata,
  output logic [RES_W-1:0]  res_out,
  output logic [DST_W-1:0]  dst_out,
  output logic [4:0]        flags_out
);

  rmode_e                  mode;
  logic signed [EXT_W-1:0] sum;
  logic [RES_W-1:0]        res_c;
  logic                    ovf_c;
  logic [RES_W-1:0]        res_d;
  logic [DST_W-1:0]        dst_d;
  rflags_t                 flags_q;

  assign mode = rmode_e'(op_mode);

  rsa_sum #(
    .DATA_W  (DATA_W),
    .GUARD_W (GUARD_W),
    .SH_PLAIN(SH_PLAIN),
    .SH_NAR  (SH_NAR),
    .SH_WIDE (SH_WIDE)
  ) u_sum (
    .mode(mode),
    .sub (op_sub),
    .a   (src_a),
    .b   (src_b),
    .sum (sum)
  );

  rsa_window #(
    .EXT_W   (EXT_W),
    .RES_W   (RES_W),
    .SH_PLAIN(SH_PLAIN),
    .SH_NAR  (SH_NAR),
    .SH_WIDE (SH_WIDE)
  ) u_win (
    .mode(mode),
    .sum (sum),
    .res (res_c),
    .ovf (ovf_c)
  );

  rsa_flags #(
    .RES_W(RES_W)
  ) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_fire(op_valid),
    .res    (res_c),
    .ovf    (ovf_c),
    .ld_en  (stat_wr),
    .ld_val (rflags_t'(stat_wdata)),
    .flags  (flags_q)
  );

  // merge into the selected half
  always_comb begin
    res_d = res_c;
    if (op_hi) dst_d = {res_c, dst_in[RES_W-1:0]};
    else       dst_d = {dst_in[DST_W-1:RES_W], res_c};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_out <= '0;
      dst_out <= '0;
    end else if (op_valid) begin
      res_out <= res_d;
      dst_out <= dst_d;
    end
  end

  assign flags_out = flags_q;

endmodule

// File: rtl/rsa_checker.sv
module rsa_checker #(
  parameter int unsigned RES_W = 16,
  localparam int unsigned DST_W = 2 * RES_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [1:0]       op_mode,
  input logic             op_hi,
  input logic [DST_W-1:0] dst_in,
  input logic             stat_wr,
  input logic [4:0]       stat_wdata,
  input logic [RES_W-1:0] res_out,
  input logic [DST_W-1:0] dst_out,
  input logic [4:0]       flags_out
);

  localparam logic [RES_W-1:0] MAX_POS = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] MAX_NEG = {1'b1, {(RES_W-1){1'b0}}};

  p_sat_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_valid && !stat_wr) && flags_out[2]) |->
      (res_out == MAX_POS || res_out == MAX_NEG));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_valid && !stat_wr && op_mode == 2'b10) |-> !flags_out[2]);

  p_zero_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_valid && !stat_wr) |->
      (flags_out[0] == (res_out == '0) && flags_out[1] == res_out[RES_W-1]));

  p_ovf_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_valid && !stat_wr) |-> flags_out[3] == flags_out[2]);

  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flags_out[4] && !stat_wr) |-> flags_out[4]);

  p_keep_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_valid && !op_hi) |->
      (dst_out[DST_W-1:RES_W] == $past(dst_in[DST_W-1:RES_W]) &&
       dst_out[RES_W-1:0] == res_out));

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stat_wr) |-> flags_out == $past(stat_wdata));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!op_valid && !stat_wr) |->
      ($stable(res_out) && $stable(dst_out) && $stable(flags_out)));

endmodule

bind rnd_sat_adder rsa_checker #(.RES_W(RES_W)) u_rsa_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_mode   (op_mode),
  .op_hi     (op_hi),
  .dst_in    (dst_in),
  .stat_wr   (stat_wr),
  .stat_wdata(stat_wdata),
  .res_out   (res_out),
  .dst_out   (dst_out),
  .flags_out (flags_out)
);

// File: tb/tb_rnd_sat_adder.sv
module tb_rnd_sat_adder;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [1:0]  op_mode;
  logic        op_sub;
  logic        op_hi;
  logic [31:0] src_a;
  logic [31:0] src_b;
  logic [31:0] dst_in;
  logic        stat_wr;
  logic [4:0]  stat_wdata;
  logic [15:0] res_out;
  logic [31:0] dst_out;
  logic [4:0]  flags_out;

  int checks = 0;
  int errors = 0;

  logic [15:0] e_res;
  logic [31:0] e_dst;
  logic [4:0]  e_flags;

  rnd_sat_adder dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode),
    .op_sub(op_sub), .op_hi(op_hi), .src_a(src_a), .src_b(src_b),
    .dst_in(dst_in), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .res_out(res_out), .dst_out(dst_out), .flags_out(flags_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // returns {ovf, result}
  function automatic logic [16:0] model(logic [1:0] m, logic s,
                                        logic [31:0] a, logic [31:0] b);
    longint sa, sb, t, q;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (s) sb = -sb;
    case (m)
      2'b01: begin t = sa + sb + 64'sd2048;   q = t >>> 12; end
      2'b10: begin t = sa + sb + 64'sd524288; q = t >>> 20; end
      default: begin t = sa + 64'sd32768;     q = t >>> 16; end
    endcase
    if (q > 64'sd32767)       model = {1'b1, 16'h7fff};
    else if (q < -64'sd32768) model = {1'b1, 16'h8000};
    else                      model = {1'b0, q[15:0]};
  endfunction

  function automatic string mtag(logic [1:0] m);
    case (m)
      2'b01:   mtag = "R3";
      2'b10:   mtag = "R4";
      2'b11:   mtag = "R12";
      default: mtag = "R1";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string rtag);
    chk(rtag, {16'h0, res_out}, {16'h0, e_res});
    chk("R8", dst_out, e_dst);
    chk("R5/R6/R7 flags", {27'h0, flags_out}, {27'h0, e_flags});
  endtask

  // called right after a falling edge; returns after the next falling edge
  task automatic do_op(logic [1:0] m, logic s, logic [31:0] a, logic [31:0] b,
                       logic hi, logic swr, logic [4:0] swd);
    logic [16:0] r;
    op_valid = 1'b1; op_mode = m; op_sub = s; op_hi = hi;
    src_a = a; src_b = b; dst_in = $urandom;
    stat_wr = swr; stat_wdata = swd;
    r = model(m, s, a, b);
    e_res = r[15:0];
    e_dst = hi ? {r[15:0], dst_in[15:0]} : {dst_in[31:16], r[15:0]};
    if (swr) e_flags = swd;
    else e_flags = {e_flags[4] | r[16], r[16], r[16], r[15], (r[15:0] == 16'h0)};
    @(negedge clk);
    check_all(mtag(m));
  endtask

  task automatic idle();
    op_valid = 1'b0; stat_wr = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; op_valid = 1'b0; op_mode = 2'b00; op_sub = 1'b0;
    op_hi = 1'b0; src_a = '0; src_b = '0; dst_in = '0;
    stat_wr = 1'b0; stat_wdata = '0;
    repeat (3) @(negedge clk);
    // R10: outputs are zero during reset
    chk("R10 res", {16'h0, res_out}, 32'h0);
    chk("R10 dst", dst_out, 32'h0);
    chk("R10 flags", {27'h0, flags_out}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    e_flags = '0;

    // R1 examples
    do_op(2'b00, 1'b0, 32'h7ff0fff0, 32'h12345678, 1'b0, 1'b0, 5'h0);
    chk("R1 round up", {16'h0, res_out}, 32'h7ff1);
    do_op(2'b00, 1'b1, 32'hfffffff0, 32'h0, 1'b1, 1'b0, 5'h0);
    chk("R1/R5 zero", {27'h0, flags_out}, 32'h01);
    do_op(2'b00, 1'b0, 32'h00fffff0, 32'hffffffff, 1'b0, 1'b0, 5'h0);
    chk("R1 carry", {16'h0, res_out}, 32'h0100);
    // R2 saturation and R7 sticky set
    do_op(2'b00, 1'b0, 32'h7ffffff0, 32'h0, 1'b0, 1'b0, 5'h0);
    chk("R2 sat", {16'h0, res_out}, 32'h7fff);
    chk("R2/R6/R7 flags", {27'h0, flags_out}, 32'h1c);
    // R7 sticky held, R6 current-only
    do_op(2'b01, 1'b0, 32'h07ffc000, 32'h00001000, 1'b1, 1'b0, 5'h0);
    chk("R3 narrow", {16'h0, res_out}, 32'h7ffd);
    chk("R6/R7 sticky held", {27'h0, flags_out}, 32'h10);
    do_op(2'b01, 1'b0, 32'h08000000, 32'h08000000, 1'b0, 1'b0, 5'h0);
    chk("R3 pos sat", {16'h0, res_out}, 32'h7fff);
    do_op(2'b01, 1'b1, 32'hcef43ed6, 32'h56f4417a, 1'b0, 1'b0, 5'h0);
    chk("R3 neg sat", {16'h0, res_out}, 32'h8000);
    chk("R5 neg flag", {27'h0, flags_out}, 32'h1e);
    do_op(2'b01, 1'b1, 32'hffffffff, 32'h00000001, 1'b0, 1'b0, 5'h0);
    chk("R12 sub to zero", {16'h0, res_out}, 32'h0);
    do_op(2'b10, 1'b0, 32'h7fff0000, 32'h0, 1'b0, 1'b0, 5'h0);
    chk("R4 wide", {16'h0, res_out}, 32'h0800);
    do_op(2'b10, 1'b0, 32'hff000000, 32'h00180000, 1'b1, 1'b0, 5'h0);
    chk("R4 wide neg", {16'h0, res_out}, 32'hfff2);
    do_op(2'b10, 1'b1, 32'h80000000, 32'h7fffffff, 1'b0, 1'b0, 5'h0);
    chk("R4 extreme no ovf", {29'h0, flags_out[4:2]}, 32'h4);
    do_op(2'b11, 1'b1, 32'h12348000, 32'h55555555, 1'b0, 1'b0, 5'h0);
    chk("R12 alias plain", {16'h0, res_out}, 32'h1235);

    // R9: status write clears sticky
    do_op(2'b10, 1'b0, 32'h00ff0000, 32'h0, 1'b0, 1'b1, 5'h00);
    chk("R9 clear", {27'h0, flags_out}, 32'h0);
    // R9 collision: overflowing op with status write in the same cycle
    do_op(2'b01, 1'b0, 32'h07ffffff, 32'h07ffffff, 1'b1, 1'b1, 5'b01010);
    chk("R9 collision flags", {27'h0, flags_out}, 32'h0a);
    chk("R9 collision res", {16'h0, res_out}, 32'h7fff);
    do_op(2'b10, 1'b0, 32'h00f00000, 32'h000f0000, 1'b0, 1'b0, 5'h0);
    chk("R7 still clear", {31'h0, flags_out[4]}, 32'h0);

    // R11 hold
    idle();
    src_a = $urandom; dst_in = $urandom;
    repeat (3) @(negedge clk);
    check_all("R11");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      logic [2:0]  sel;
      sel = 3'($urandom_range(0, 4));
      a = $urandom; b = $urandom;
      if (sel == 3'd1) begin a = a >>> 4; b = b >>> 4; end
      if (sel == 3'd2) begin a = {{8{a[31]}}, a[23:0]}; b = 32'h0; end
      do_op(2'($urandom), 1'($urandom), a, b, 1'($urandom),
            ($urandom_range(0, 15) == 0), 5'($urandom));
      if ((i % 50) == 49) begin
        idle();
        @(negedge clk);
        check_all("R11");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule